// File: doc/BRIEF.md
# Three-Channel Power-Good Aggregator with Dip Blanking

This block watches the sampled output-voltage codes of three regulator channels against each channel's programmed target code and produces a single combined power-good indication. Each channel holds its own small state machine. A channel qualifies as good once its measured code reaches 92 % of its target. It then stays good until the measured code drops below 88 % of the target. That gap between the two thresholds is the hysteresis.

An undervoltage dip on a good channel is not reported at once. The dip must last a programmable number of consecutive clock cycles (`BLANK_CYC`, 200 by default, which is 2 µs at 100 MHz) before the channel falls back to not-good. Channels whose enable flag is low are left out of the combined result. The result drives an active-low open-drain pin through a drive-enable: `pg_drive_low` is high whenever the combination is not good, and also when no channel is enabled.

Per-channel states are `CH_LOW` (not qualified), `CH_GOOD` (qualified) and `CH_DIP` (qualified, but below the falling threshold while the blanking counter runs). The transitions are:
- LOW→GOOD when the measured code reaches the rising threshold.
- GOOD→DIP on a sample below the falling threshold.
- DIP→GOOD when the code recovers.
- DIP→LOW on the `BLANK_CYC`-th consecutive bad sample.
- any→LOW when the channel is disabled.

Top module: `pg_agg`

## Requirements
- R1: A channel in CH_LOW whose measured code m and target t satisfy m*100 >= t*92 at a clock edge is good after that edge.
- R2: A channel in CH_LOW with m*100 < t*92 stays not good, even when it is above the falling threshold.
- R3: A good channel with m*100 >= t*88 stays good.
- R4: A good channel whose samples satisfy m*100 < t*88 for fewer than BLANK_CYC consecutive edges stays good, and a recovering sample returns it to CH_GOOD.
- R5: A good channel whose samples are below the falling threshold for BLANK_CYC consecutive edges is not good after the BLANK_CYC-th of those edges.
- R6: pg_drive_low is 0 only when at least one channel is enabled and every enabled channel is good; otherwise it is 1.
- R7: A channel whose enable bit is 0 does not affect pg_drive_low, and it returns to CH_LOW at the next edge, so after re-enabling it must meet the rising threshold again.
- R8: When ch_en is 3'b000, pg_drive_low is 1.
- R9: While rst_n is low, and after its release, all channels are in CH_LOW and pg_drive_low is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Per-channel enable; bit i belongs to channel i |
| meas_code | input | NCH*CODE_W | Measured codes; channel i occupies bits [i*CODE_W +: CODE_W] |
| tgt_code | input | NCH*CODE_W | Programmed target codes, packed the same way as meas_code |
| pg_drive_low | output | 1 | Open-drain pull-down enable; 1 means power not good |

## Verification
The assertions assume that the codes and enables are synchronous to `clk` and stable across each sampling edge. They also assume that `BLANK_CYC` is at least 2, so that a single-cycle dip can never clear a channel. The stimulus changes every input only just after a rising edge, with all targets held constant within a test. Dip lengths are chosen at 1, 5, `BLANK_CYC`-1 and `BLANK_CYC` edges, so that both sides of the blanking boundary are reached.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic [1:0] {
        CH_LOW  = 2'd0,
        CH_GOOD = 2'd1,
        CH_DIP  = 2'd2
    } ch_state_t;
endpackage

// File: rtl/pg_thresh.sv
module pg_thresh #(
    parameter int CODE_W = 10,
    parameter int PCT    = 92
) (
    input  logic [CODE_W-1:0] meas,
    input  logic [CODE_W-1:0] tgt,
    output logic              at_or_above
);
    localparam int PROD_W = CODE_W + 8;

    logic [PROD_W-1:0] meas_scaled;
    logic [PROD_W-1:0] tgt_scaled;

    always_comb begin
        meas_scaled = PROD_W'(meas) * PROD_W'(100);
        tgt_scaled  = PROD_W'(tgt) * PROD_W'(PCT);
        at_or_above = (meas_scaled >= tgt_scaled);
    end
endmodule

// File: rtl/pg_chan.sv
module pg_chan
    import pg_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int BLANK_CYC = 200,
    parameter int RISE_PCT  = 92,
    parameter int FALL_PCT  = 88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] meas,
    input  logic [CODE_W-1:0] tgt,
    output logic              good
);
    localparam int CNT_W = $clog2(BLANK_CYC + 1);

    ch_state_t        st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             above_rise;
    logic             above_fall;

    pg_thresh #(.CODE_W(CODE_W), .PCT(RISE_PCT)) u_rise (
        .meas(meas), .tgt(tgt), .at_or_above(above_rise)
    );

    pg_thresh #(.CODE_W(CODE_W), .PCT(FALL_PCT)) u_fall (
        .meas(meas), .tgt(tgt), .at_or_above(above_fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CH_LOW;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = '0;
        if (!en) begin
            st_nx = CH_LOW;
        end else begin
            unique case (st)
                CH_LOW: begin
                    if (above_rise) st_nx = CH_GOOD;
                end
                CH_GOOD: begin
                    if (!above_fall) begin
                        st_nx  = CH_DIP;
                        cnt_nx = CNT_W'(1);
                    end
                end
                CH_DIP: begin
                    if (above_fall) begin
                        st_nx = CH_GOOD;
                    end else if (cnt >= CNT_W'(BLANK_CYC - 1)) begin
                        st_nx = CH_LOW;
                    end else begin
                        st_nx  = CH_DIP;
                        cnt_nx = cnt + CNT_W'(1);
                    end
                end
                default: st_nx = CH_LOW;
            endcase
        end
    end

    always_comb begin
        good = (st == CH_GOOD) || (st == CH_DIP);
    end

    p_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == CH_LOW && above_rise) |=> good);

    p_stay_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == CH_LOW && !above_rise) |=> !good);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && good && above_fall) |=> (st == CH_GOOD));

    p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == CH_GOOD) |=> good);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < CNT_W'(BLANK_CYC)));

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == CH_LOW));
endmodule

// File: rtl/pg_agg.sv
module pg_agg #(
    parameter int NCH       = 3,
    parameter int CODE_W    = 10,
    parameter int BLANK_CYC = 200,
    parameter int RISE_PCT  = 92,
    parameter int FALL_PCT  = 88
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ch_en,
    input  logic [NCH*CODE_W-1:0] meas_code,
    input  logic [NCH*CODE_W-1:0] tgt_code,
    output logic                  pg_drive_low
);
    logic [NCH-1:0] ch_good;
    logic           all_ok;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pg_chan #(
            .CODE_W(CODE_W), .BLANK_CYC(BLANK_CYC),
            .RISE_PCT(RISE_PCT), .FALL_PCT(FALL_PCT)
        ) u_ch (
            .clk(clk),
            .rst_n(rst_n),
            .en(ch_en[i]),
            .meas(meas_code[i*CODE_W +: CODE_W]),
            .tgt(tgt_code[i*CODE_W +: CODE_W]),
            .good(ch_good[i])
        );
    end

    always_comb begin
        all_ok = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (ch_en[i] && !ch_good[i]) all_ok = 1'b0;
        end
        pg_drive_low = !(all_ok && (|ch_en));
    end

    p_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> pg_drive_low);

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_drive_low |-> ((ch_en & ~ch_good) == '0));

    p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> pg_drive_low);
endmodule

// File: tb/sim_pg_agg.sv
module sim_pg_agg;
    localparam int NCH = 3;
    localparam int CW  = 10;
    localparam int BLK = 200;
    localparam int NV  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ch_en = '0;
    logic [NCH*CW-1:0] meas_code = '0;
    logic [NCH*CW-1:0] tgt_code = '0;
    logic              pg_drive_low;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pg_agg #(.NCH(NCH), .CODE_W(CW), .BLANK_CYC(BLK)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en),
        .meas_code(meas_code), .tgt_code(tgt_code),
        .pg_drive_low(pg_drive_low)
    );

    // entry: {en[2:0], m2, m1, m0, cycles[15:0], expected drive_low}, all targets 500
    localparam logic [49:0] VEC [NV] = '{
        {3'b111, 10'd460, 10'd460, 10'd460, 16'd2,   1'b0}, // R1 exact rise
        {3'b111, 10'd459, 10'd459, 10'd459, 16'd3,   1'b0}, // R3 below rise, stays
        {3'b111, 10'd440, 10'd440, 10'd440, 16'd3,   1'b0}, // R3 fall boundary
        {3'b111, 10'd500, 10'd500, 10'd439, 16'd5,   1'b0}, // R4 short dip
        {3'b111, 10'd500, 10'd500, 10'd500, 16'd2,   1'b0}, // R4 recover
        {3'b111, 10'd500, 10'd500, 10'd439, 16'(BLK), 1'b1}, // R5 full dip
        {3'b111, 10'd500, 10'd500, 10'd459, 16'd3,   1'b1}, // R2 no rise yet
        {3'b110, 10'd500, 10'd500, 10'd459, 16'd1,   1'b0}, // R7 ch0 ignored
        {3'b111, 10'd500, 10'd500, 10'd459, 16'd2,   1'b1}, // R7 requalify needed
        {3'b111, 10'd500, 10'd500, 10'd460, 16'd1,   1'b0}, // R1 requalified
        {3'b000, 10'd500, 10'd500, 10'd500, 16'd1,   1'b1}, // R8 none enabled
        {3'b001, 10'd500, 10'd300, 10'd500, 16'd2,   1'b0}  // R7 R6 only ch0 counts
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input logic exp, input string req);
        total++;
        if (pg_drive_low !== exp) begin
            bad++;
            $display("FAIL %s: pg_drive_low=%b expected=%b", req, pg_drive_low, exp);
        end
    endtask

    task automatic set_all(input logic [2:0] en, input int m0, input int m1, input int m2);
        ch_en = en;
        meas_code = {CW'(m2), CW'(m1), CW'(m0)};
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tgt_code = {10'd500, 10'd500, 10'd500};
        set_all(3'b111, 500, 500, 500);
        #2;
        check(1'b1, "R9 in reset");
        tick(2);
        check(1'b1, "R9 held reset");
        rst_n = 1'b1;
        #1;
        check(1'b1, "R9 after release");
        tick(1);
        // the first edge after release sees 500 >= 460, so all channels qualify (R1)
        check(1'b0, "R1 after reset");
        set_all(3'b111, 439, 439, 439);
        tick(1);
        // one bad sample cannot clear the channel (R4)
        check(1'b0, "R4 single dip");
        set_all(3'b111, 460, 460, 460);
        tick(1);

        for (int v = 0; v < NV; v++) begin
            ch_en     = VEC[v][49:47];
            meas_code = VEC[v][46:17];
            tick(int'(VEC[v][16:1]));
            check(VEC[v][0], $sformatf("R6 vector %0d", v));
        end

        // R5 boundary: BLK-1 bad edges keep the flag, the BLK-th clears it
        set_all(3'b111, 500, 500, 500);
        tick(2);
        check(1'b0, "R6 all good");
        set_all(3'b111, 500, 439, 500);
        tick(BLK - 1);
        check(1'b0, "R4 dip of BLK-1");
        tick(1);
        check(1'b1, "R5 dip of BLK");

        // a different target: 1000 gives a rise at 920 and a fall below 880
        rst_n = 1'b0;
        #1;
        tgt_code = {10'd1000, 10'd1000, 10'd1000};
        set_all(3'b010, 0, 919, 0);
        tick(1);
        rst_n = 1'b1;
        tick(2);
        check(1'b1, "R2 919 of 1000");
        set_all(3'b010, 0, 920, 0);
        tick(1);
        check(1'b0, "R1 920 of 1000");
        set_all(3'b010, 0, 880, 0);
        tick(BLK + 2);
        check(1'b0, "R3 880 of 1000 held");
        set_all(3'b010, 0, 879, 0);
        tick(BLK);
        check(1'b1, "R5 879 of 1000");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule